// File: doc/BRIEF.md
# Exception and Privileged-Mode Control Unit

This unit gives a simple single-issue processor its exception machinery. It keeps the small set of privileged coprocessor registers: the return PC, the recorded cause, the faulting address and the enable mask. It also keeps the single bit that says whether the core runs in privileged or user mode. Each cycle it looks at the exception request lines that the datapath raises for the instruction at the current PC. If any enabled request is present, it redirects fetch to a fixed handler address, kills the architectural writes of that instruction and, at the next clock edge, records the PC and the cause and enters privileged mode.

The decode stage presents three privileged-instruction strobes: read from a coprocessor register, write to a coprocessor register, and return from exception. Together with them it gives a coprocessor register number and the general-register value to be written. In privileged mode the unit carries these out. In user mode any of them turns into an illegal-instruction exception. The return instruction redirects fetch to the saved PC and drops the core back to user mode. A system call enters the handler through exactly the same path as a fault.

Top module: `trap_unit`

## Requirements
- R1: After reset the unit is in privileged mode (`priv_mode`=1), and the mask, saved PC, cause and fault-address registers all read as zero.
- R2: When an exception is taken, `redirect`=1, `redirect_pc`=0x0000_0080 and `kill`=1 in that same cycle. From the next cycle on, `priv_mode`=1 and register 14 holds the `cur_pc` of the trapping cycle.
- R3: Register 13 holds the code of the last taken exception in bits [4:0], with all upper bits zero. The codes are: interrupt 0, address fault 4, system call 8, illegal instruction 10, overflow 12.
- R4: A taken address fault copies `fault_addr` into register 8. Any other taken exception leaves register 8 unchanged.
- R5: Register 12 is the mask. Interrupt, address fault and overflow are taken only while mask bit 0, 4 or 12 respectively is set. System call and illegal instruction are always taken. A masked request has no effect: no redirect, no kill, and no register change.
- R6: When several enabled requests are present in the same cycle, the one with the lowest cause code is taken.
- R7: In privileged mode `cp_rdata` shows the register chosen by `cp_sel` (8, 12, 13 or 14), and any other number reads 0. In user mode `cp_rdata` is 0.
- R8: A privileged coprocessor write loads `gpr_wdata` into the register chosen by `cp_sel` (8, 12 or 14 in full; 13 keeps bits [4:0]), effective next cycle. Any other register number is ignored.
- R9: In user mode, a coprocessor read, coprocessor write or return strobe raises an illegal-instruction exception (code 10) and is not carried out.
- R10: A privileged return with no exception taken sets `redirect`=1 with `redirect_pc` equal to register 14 in that cycle, and `priv_mode`=0 from the next cycle.
- R11: When an exception is taken in the same cycle as a privileged coprocessor write or return, the write and the return are not carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction presented this cycle |
| req_irq | input | 1 | External interrupt request |
| req_addr_fault | input | 1 | Address (page/protection) fault request |
| fault_addr | input | 32 | Address that caused the fault |
| req_syscall | input | 1 | System call request |
| req_illegal | input | 1 | Illegal instruction request from decode |
| req_overflow | input | 1 | Arithmetic overflow request |
| op_cp_read | input | 1 | Decoded coprocessor read strobe |
| op_cp_write | input | 1 | Decoded coprocessor write strobe |
| op_return | input | 1 | Decoded return-from-exception strobe |
| cp_sel | input | 5 | Coprocessor register number |
| gpr_wdata | input | 32 | General-register value for a coprocessor write |
| redirect | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | 32 | Handler address or saved return PC |
| kill | output | 1 | Suppress the current instruction's register and memory writes |
| cp_rdata | output | 32 | Selected coprocessor register value |
| priv_mode | output | 1 | 1 = privileged, 0 = user |

## Verification
The embedded assertions check these properties on every cycle: a system call is never masked; a simultaneous system call never loses to a higher code; every taken exception saves the PC and raises privileged mode; a non-fault exception leaves the fault address alone; a user-mode privileged strobe always traps to the handler without touching the mask; and a clean privileged return drops to user mode. Some behaviour can only be shown by the bench scenarios and its per-cycle reference model. This covers the exact cause codes and the full priority order, mask gating of each maskable source, register write and read-back through the coprocessor port, the hiding of register values in user mode, and the suppression of a write or return that coincides with an exception.

// File: rtl/trap_pkg.sv
// trap_pkg: shared constants for the exception unit.
// Assumes a 32-bit machine and five exception sources, listed in
// ascending cause-code order so that a lower index means higher priority.
package trap_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;
    localparam int SEL_W  = 5;
    localparam int N_SRC  = 5;

    // Source indices, sorted by rising cause code
    localparam int IDX_IRQ  = 0;
    localparam int IDX_ADDR = 1;
    localparam int IDX_SYS  = 2;
    localparam int IDX_ILL  = 3;
    localparam int IDX_OVF  = 4;

    // Cause codes
    localparam logic [CODE_W-1:0] CODE_IRQ  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_ADDR = 5'd4;
    localparam logic [CODE_W-1:0] CODE_SYS  = 5'd8;
    localparam logic [CODE_W-1:0] CODE_ILL  = 5'd10;
    localparam logic [CODE_W-1:0] CODE_OVF  = 5'd12;

    // Coprocessor register numbers
    localparam logic [SEL_W-1:0] REG_BADADDR = 5'd8;
    localparam logic [SEL_W-1:0] REG_MASK    = 5'd12;
    localparam logic [SEL_W-1:0] REG_CAUSE   = 5'd13;
    localparam logic [SEL_W-1:0] REG_EPC     = 5'd14;

    // Cause code for each source index
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            IDX_IRQ:  return CODE_IRQ;
            IDX_ADDR: return CODE_ADDR;
            IDX_SYS:  return CODE_SYS;
            IDX_ILL:  return CODE_ILL;
            default:  return CODE_OVF;
        endcase
    endfunction

    // Whether a source can be held off by the mask register
    function automatic logic src_maskable(input int idx);
        return (idx == IDX_IRQ) || (idx == IDX_ADDR) || (idx == IDX_OVF);
    endfunction
endpackage

// File: rtl/trap_arbiter.sv
// trap_arbiter: gates each request with its mask bit and picks the enabled
// request with the lowest cause code. Purely combinational; clk/rst_n
// are only used by the embedded assertions.
// Assumes req[] is ordered by rising cause code (see trap_pkg).
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int WIDTH = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req,
    input  logic [WIDTH-1:0]  mask,
    output logic              take,
    output logic [CODE_W-1:0] code
);
    logic [NSRC-1:0] enabled;
    logic [NSRC-1:0] grant;

    // Per-source enable: unmaskable sources pass, the others need their mask bit
    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign enabled[g] = req[g] & (~src_maskable(g) | mask[src_code(g)]);
    end

    // Priority pick: scan from the highest index down so the lowest index stays
    always_comb begin
        grant = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (enabled[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    // Encode the granted source into its cause code
    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) code = code | src_code(i);
        end
    end

    assign take = |enabled;

    AST_SYS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        req[IDX_SYS] |-> take); // R5
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req[IDX_SYS] |-> (code <= CODE_SYS)); // R6
    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
endmodule

// File: rtl/cp0_bank.sv
// cp0_bank: the four privileged coprocessor registers and their read mux.
// Assumes wr_en is already qualified with privilege and with "no exception
// taken" by the caller; a taken exception updates the saved PC, cause and
// (for address faults) the fault address.
module cp0_bank
    import trap_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_take,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [WIDTH-1:0]  cur_pc,
    input  logic [WIDTH-1:0]  fault_addr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  mask,
    output logic [WIDTH-1:0]  epc,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0]  epc_q;
    logic [WIDTH-1:0]  bad_q;
    logic [WIDTH-1:0]  mask_q;
    logic [CODE_W-1:0] cause_q;

    // Saved return PC: captured on trap, otherwise software-writable
    always_ff @(posedge clk) begin
        if (!rst_n)                           epc_q <= '0;
        else if (trap_take)                   epc_q <= cur_pc;
        else if (wr_en && sel == REG_EPC)     epc_q <= wdata;
    end

    // Cause code: written on trap, low bits writable by software
    always_ff @(posedge clk) begin
        if (!rst_n)                           cause_q <= '0;
        else if (trap_take)                   cause_q <= trap_code;
        else if (wr_en && sel == REG_CAUSE)   cause_q <= wdata[CODE_W-1:0];
    end

    // Fault address: only an address fault records it
    always_ff @(posedge clk) begin
        if (!rst_n)                                   bad_q <= '0;
        else if (trap_take && trap_code == CODE_ADDR) bad_q <= fault_addr;
        else if (wr_en && sel == REG_BADADDR)         bad_q <= wdata;
    end

    // Enable mask: software-owned, cleared at reset
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_q <= '0;
        else if (wr_en && sel == REG_MASK)    mask_q <= wdata;
    end

    // Read mux: unknown register numbers read zero
    always_comb begin
        case (sel)
            REG_EPC:     rdata = epc_q;
            REG_CAUSE:   rdata = WIDTH'(cause_q);
            REG_BADADDR: rdata = bad_q;
            REG_MASK:    rdata = mask_q;
            default:     rdata = '0;
        endcase
    end

    assign mask = mask_q;
    assign epc  = epc_q;

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (epc_q == $past(cur_pc))); // R2
    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && trap_code != CODE_ADDR) |=> $stable(bad_q)); // R4
endmodule

// File: rtl/priv_state.sv
// priv_state: the one-bit privilege mode. Reset and exception entry set
// privileged mode; a qualified return clears it.
// Assumes enter and leave are never asserted together (the caller masks
// leave with the trap).
module priv_state (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    output logic priv
);
    logic priv_q;

    // Mode register: privileged after reset and on every trap
    always_ff @(posedge clk) begin
        if (!rst_n)      priv_q <= 1'b1;
        else if (enter)  priv_q <= 1'b1;
        else if (leave)  priv_q <= 1'b0;
    end

    assign priv = priv_q;

    AST_TRAP_TO_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> priv_q); // R2
endmodule

// File: rtl/trap_unit.sv
// trap_unit: top of the exception and privileged-mode control unit.
// Turns request lines and privileged-instruction strobes into a fetch
// redirect, a write kill and coprocessor register updates.
// Assumes at most one of op_cp_read/op_cp_write/op_return per cycle and
// that all inputs describe the instruction at cur_pc.
module trap_unit
    import trap_pkg::*;
#(
    parameter int                WIDTH   = XLEN,
    parameter logic [WIDTH-1:0]  HANDLER = WIDTH'(32'h0000_0080)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  cur_pc,
    input  logic              req_irq,
    input  logic              req_addr_fault,
    input  logic [WIDTH-1:0]  fault_addr,
    input  logic              req_syscall,
    input  logic              req_illegal,
    input  logic              req_overflow,
    input  logic              op_cp_read,
    input  logic              op_cp_write,
    input  logic              op_return,
    input  logic [SEL_W-1:0]  cp_sel,
    input  logic [WIDTH-1:0]  gpr_wdata,
    output logic              redirect,
    output logic [WIDTH-1:0]  redirect_pc,
    output logic              kill,
    output logic [WIDTH-1:0]  cp_rdata,
    output logic              priv_mode
);
    logic              priv;
    logic              priv_op;
    logic              violation;
    logic [N_SRC-1:0]  req_vec;
    logic              take;
    logic [CODE_W-1:0] code;
    logic              ret_ok;
    logic              wr_ok;
    logic [WIDTH-1:0]  mask;
    logic [WIDTH-1:0]  epc;
    logic [WIDTH-1:0]  raw_rdata;

    // Privilege check: any privileged strobe in user mode becomes illegal
    always_comb begin
        priv_op   = op_cp_read | op_cp_write | op_return;
        violation = priv_op & ~priv;
    end

    // Request vector in priority (cause-code) order
    always_comb begin
        req_vec           = '0;
        req_vec[IDX_IRQ]  = req_irq;
        req_vec[IDX_ADDR] = req_addr_fault;
        req_vec[IDX_SYS]  = req_syscall;
        req_vec[IDX_ILL]  = req_illegal | violation;
        req_vec[IDX_OVF]  = req_overflow;
    end

    trap_arbiter #(.NSRC(N_SRC), .WIDTH(WIDTH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_vec),
        .mask  (mask),
        .take  (take),
        .code  (code)
    );

    // Privileged operations proceed only when no exception is taken
    always_comb begin
        ret_ok = op_return & priv & ~take;
        wr_ok  = op_cp_write & priv & ~take;
    end

    cp0_bank #(.WIDTH(WIDTH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_take  (take),
        .trap_code  (code),
        .cur_pc     (cur_pc),
        .fault_addr (fault_addr),
        .wr_en      (wr_ok),
        .sel        (cp_sel),
        .wdata      (gpr_wdata),
        .mask       (mask),
        .epc        (epc),
        .rdata      (raw_rdata)
    );

    priv_state u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (take),
        .leave (ret_ok),
        .priv  (priv)
    );

    // Fetch redirect: the handler on a trap, the saved PC on a return
    always_comb begin
        redirect    = take | ret_ok;
        redirect_pc = take ? HANDLER : epc;
        kill        = take;
    end

    // Register read port, hidden from user mode
    always_comb begin
        cp_rdata  = priv ? raw_rdata : '0;
        priv_mode = priv;
    end

    AST_USER_OP_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_mode && priv_op) |-> (redirect && kill && redirect_pc == HANDLER)); // R9
    AST_USER_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_mode && op_cp_write) |=> $stable(mask)); // R9
    AST_RETURN_TO_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode && op_return && !kill) |=> !priv_mode); // R10
    AST_TRAP_BLOCKS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_return && kill) |=> priv_mode); // R11
endmodule

// File: tb/trap_unit_test.sv
// Bench: behavioural reference model, compared on every cycle.
module trap_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        req_irq = 0, req_addr_fault = 0, req_syscall = 0;
    logic        req_illegal = 0, req_overflow = 0;
    logic [31:0] fault_addr = '0;
    logic        op_cp_read = 0, op_cp_write = 0, op_return = 0;
    logic [4:0]  cp_sel = '0;
    logic [31:0] gpr_wdata = '0;
    logic        redirect, kill, priv_mode;
    logic [31:0] redirect_pc, cp_rdata;

    int checks = 0;
    int errors = 0;

    // Reference state
    bit          m_priv;
    logic [31:0] m_epc, m_bad, m_mask;
    logic [4:0]  m_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_unit uut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc),
        .req_irq(req_irq), .req_addr_fault(req_addr_fault), .fault_addr(fault_addr),
        .req_syscall(req_syscall), .req_illegal(req_illegal), .req_overflow(req_overflow),
        .op_cp_read(op_cp_read), .op_cp_write(op_cp_write), .op_return(op_return),
        .cp_sel(cp_sel), .gpr_wdata(gpr_wdata),
        .redirect(redirect), .redirect_pc(redirect_pc), .kill(kill),
        .cp_rdata(cp_rdata), .priv_mode(priv_mode)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_reg(input logic [4:0] sel);
        if (sel == 5'd14) return m_epc;
        if (sel == 5'd13) return {27'd0, m_cause};
        if (sel == 5'd12) return m_mask;
        if (sel == 5'd8)  return m_bad;
        return 32'd0;
    endfunction

    // Lowest pending code, or -1 when nothing is taken
    function automatic int m_pick();
        logic [31:0] pend;
        pend = '0;
        pend[0]  = req_irq & m_mask[0];
        pend[4]  = req_addr_fault & m_mask[4];
        pend[8]  = req_syscall;
        pend[10] = req_illegal | ((op_cp_read | op_cp_write | op_return) & !m_priv);
        pend[12] = req_overflow & m_mask[12];
        for (int c = 0; c < 32; c++) if (pend[c]) return c;
        return -1;
    endfunction

    task automatic idle();
        req_irq = 0; req_addr_fault = 0; req_syscall = 0;
        req_illegal = 0; req_overflow = 0;
        op_cp_read = 0; op_cp_write = 0; op_return = 0;
    endtask

    // One cycle: compare outputs mid-cycle, then advance the model at the edge
    task automatic cycle(input string tag);
        int  code;
        bit  ret;
        logic [31:0] exp_pc;
        @(negedge clk);
        code = m_pick();
        ret  = op_return && m_priv && code < 0;
        exp_pc = (code >= 0) ? HANDLER : m_epc;
        check(tag, "redirect", {31'd0, redirect}, {31'd0, (code >= 0) || ret});
        if ((code >= 0) || ret) check(tag, "redirect_pc", redirect_pc, exp_pc);
        check(tag, "kill", {31'd0, kill}, {31'd0, code >= 0});
        check(tag, "priv_mode", {31'd0, priv_mode}, {31'd0, m_priv});
        check(tag, "cp_rdata", cp_rdata, m_priv ? m_reg(cp_sel) : 32'd0);
        @(posedge clk);
        if (code >= 0) begin
            m_epc = cur_pc;
            m_cause = 5'(code);
            if (code == 4) m_bad = fault_addr;
            m_priv = 1;
        end else if (m_priv) begin
            if (op_cp_write) begin
                if (cp_sel == 5'd14) m_epc = gpr_wdata;
                if (cp_sel == 5'd13) m_cause = gpr_wdata[4:0];
                if (cp_sel == 5'd12) m_mask = gpr_wdata;
                if (cp_sel == 5'd8)  m_bad = gpr_wdata;
            end
            if (op_return) m_priv = 0;
        end
        #1;
    endtask

    task automatic cp_write(input logic [4:0] sel, input logic [31:0] val, input string tag);
        idle(); op_cp_write = 1; cp_sel = sel; gpr_wdata = val;
        cycle(tag);
        idle();
    endtask

    task automatic cp_read(input logic [4:0] sel, input string tag);
        idle(); op_cp_read = 1; cp_sel = sel;
        cycle(tag);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_priv = 1; m_epc = '0; m_bad = '0; m_mask = '0; m_cause = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state, each register reads zero in privileged mode
        foreach (uut.HANDLER[i]) ; // no-op keeps loop syntax local
        cp_sel = 5'd8;  cycle("R1");
        cp_sel = 5'd12; cycle("R1");
        cp_sel = 5'd13; cycle("R1");
        cp_sel = 5'd14; cycle("R1");

        // R8: writes and read-back, unknown number ignored
        cp_write(5'd14, 32'h0000_1234, "R8");
        cp_read(5'd14, "R8");
        cp_write(5'd13, 32'hFFFF_FFFF, "R8");
        cp_read(5'd13, "R8");
        cp_write(5'd8, 32'hCAFE_0000, "R8");
        cp_write(5'd5, 32'h5555_5555, "R8");
        cp_read(5'd5, "R7");
        cp_read(5'd8, "R7");

        // R5: maskable sources ignored while the mask is clear
        idle(); req_overflow = 1; cur_pc = 32'h200; cp_sel = 5'd14; cycle("R5");
        idle(); req_irq = 1; cycle("R5");
        idle(); req_addr_fault = 1; fault_addr = 32'h1111; cp_sel = 5'd8; cycle("R5");
        idle(); cycle("R5");

        // R2 R3: system call entry
        idle(); req_syscall = 1; cur_pc = 32'h400; cycle("R2");
        idle(); cp_sel = 5'd13; cycle("R3");
        cp_sel = 5'd14; cycle("R2");

        // R5: enable maskable sources, overflow now taken
        cp_write(5'd12, 32'h0000_1011, "R5");
        idle(); req_overflow = 1; cur_pc = 32'h440; cycle("R5");
        idle(); cp_sel = 5'd13; cycle("R3");

        // R4: address fault records address, later syscall keeps it
        idle(); req_addr_fault = 1; fault_addr = 32'hDEAD_BEEF; cur_pc = 32'h480; cycle("R4");
        idle(); cp_sel = 5'd8; cycle("R4");
        idle(); req_syscall = 1; fault_addr = 32'h0BAD_0BAD; cycle("R4");
        idle(); cp_sel = 5'd8; cycle("R4");

        // R6: priority among simultaneous requests
        idle(); req_irq = 1; req_addr_fault = 1; req_syscall = 1; req_illegal = 1; req_overflow = 1;
        cur_pc = 32'h500; cycle("R6");
        idle(); cp_sel = 5'd13; cycle("R6");
        idle(); req_syscall = 1; req_overflow = 1; cycle("R6");
        idle(); cycle("R6");
        idle(); req_illegal = 1; req_overflow = 1; cycle("R6");
        idle(); cycle("R6");
        idle(); req_addr_fault = 1; req_syscall = 1; fault_addr = 32'h7777; cycle("R6");
        idle(); cycle("R6");

        // R11: trap in the same cycle as a write or a return
        cp_write(5'd14, 32'h0000_3000, "R8");
        idle(); req_syscall = 1; op_cp_write = 1; cp_sel = 5'd12; gpr_wdata = 32'h0;
        cur_pc = 32'h600; cycle("R11");
        idle(); cp_sel = 5'd12; cycle("R11");
        idle(); req_overflow = 1; op_return = 1; cur_pc = 32'h640; cycle("R11");
        idle(); cp_sel = 5'd14; cycle("R11");

        // R10: return to the saved PC and to user mode
        cp_write(5'd14, 32'h0000_2000, "R10");
        idle(); op_return = 1; cycle("R10");
        idle(); cp_sel = 5'd14; cycle("R7");
        cp_sel = 5'd12; cycle("R7");

        // R9: privileged strobes in user mode trap as illegal
        idle(); op_cp_write = 1; cp_sel = 5'd12; gpr_wdata = 32'h0; cur_pc = 32'h2004; cycle("R9");
        idle(); cp_sel = 5'd13; cycle("R9");
        cp_sel = 5'd12; cycle("R9");
        idle(); op_return = 1; cycle("R10");
        idle(); op_return = 1; cur_pc = 32'h2008; cycle("R9");
        idle(); cp_sel = 5'd14; cycle("R9");
        cp_write(5'd14, 32'h0000_2100, "R10");
        idle(); op_return = 1; cycle("R10");
        idle(); op_cp_read = 1; cp_sel = 5'd13; cur_pc = 32'h2100; cycle("R9");
        idle(); cp_sel = 5'd13; cycle("R9");

        // R6: mixed random traffic
        for (int n = 0; n < 2000; n++) begin
            int sel_pick;
            int op_pick;
            idle();
            cur_pc         = $urandom & 32'hFFFF_FFFC;
            fault_addr     = $urandom;
            gpr_wdata      = $urandom;
            req_irq        = ($urandom % 8) == 0;
            req_addr_fault = ($urandom % 10) == 0;
            req_syscall    = ($urandom % 12) == 0;
            req_illegal    = ($urandom % 12) == 0;
            req_overflow   = ($urandom % 10) == 0;
            sel_pick = int'($urandom % 5);
            case (sel_pick)
                0: cp_sel = 5'd8;
                1: cp_sel = 5'd12;
                2: cp_sel = 5'd13;
                3: cp_sel = 5'd14;
                default: cp_sel = 5'($urandom);
            endcase
            op_pick = int'($urandom % 6);
            if (op_pick == 0) op_cp_read = 1;
            if (op_pick == 1) op_cp_write = 1;
            if (op_pick == 2) op_return = 1;
            cycle("R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule